// File: doc/BRIEF.md
# Dual-Source External Interrupt Latch

This block turns external interrupt pins into one latched interrupt request for the processor. A dedicated active-low interrupt pin and an optional secondary port pin are each synchronized. The secondary pin is admitted only while its enable bit is set and a neighbouring serial peripheral reports itself disabled. Admitted sources are combined by logical AND of their active-low levels, so a low on either source pulls the combined level low. A falling edge of the combined level, or in level mode a low level, sets one shared request latch. An event admitted from the secondary pin also raises a flag of its own.

Software reaches the block through a two-register bus. The control/status register holds the request mask, the trigger mode, a write-only acknowledge bit, the latch state and the synchronized pin level. The option register holds the secondary-pin enable, the secondary-pin flag and a bit that turns the pin pullup off. A debug break input protects the latch and the flag from acknowledge writes. A break clear-enable input lifts that protection.

Top module: `ext_irq_unit`

## Requirements
- R1: After synchronous reset, `cpu_irq` is 0 and `pullup_en` is 1. The control register (address 0) reads 0x10 while both pins are high. The option register (address 1) reads 0x00. Mask, trigger mode (edge), secondary enable, secondary flag and pullup-disable are all 0.
- R2: In edge mode (control bit 2 = 0), a high-to-low change on `irq_n` sets the latch (control bit 3). If the change is applied before rising edge 1, the latch is visible after rising edge 3, and `cpu_irq` rises then when unmasked.
- R3: `sec_pin` is a source only while option bit 0 is 1 and `usb_en` is 0. Its falling edge then sets the same latch. Otherwise it has no effect on the latch, the flag or the pin-level bit.
- R4: An event from the admitted secondary pin sets option bit 1. Writing 1 to option bit 1 clears it.
- R5: Control bit 0 (mask) = 1 holds `cpu_irq` at 0 but does not stop the latch from setting. Clearing the mask with the latch set raises `cpu_irq` after the next rising edge.
- R6: Outside the break state, writing 1 to control bit 1 (acknowledge) clears the latch after the next rising edge. Control bit 1 always reads 0.
- R7: While `brk_state` is 1 and `brk_clr_en` is 0, acknowledge writes leave the latch unchanged, and writes of 1 to option bit 1 leave the secondary flag unchanged.
- R8: While `brk_state` is 1 and `brk_clr_en` is 1, an acknowledge write clears the latch. The latch stays clear after `brk_state` returns to 0.
- R9: In level mode (control bit 2 = 1), the latch sets on every cycle in which the synchronized combined level is low. It is set again right after an acknowledge while the pin stays low.
- R10: Control bit 4 reads the synchronized combined level: 0 when `irq_n` or an admitted `sec_pin` is low. It follows the pin two rising edges after the change.
- R11: `pullup_en` equals the inverse of option bit 2 (pullup-disable).
- R12: When a trigger event and an acknowledge write fall in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Dedicated active-low interrupt pin |
| sec_pin | input | 1 | Secondary active-low interrupt pin |
| usb_en | input | 1 | High while the neighbouring peripheral that shares the secondary pin is enabled |
| brk_state | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allows acknowledge writes to clear during break |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control/status, 1 option |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| cpu_irq | output | 1 | Interrupt request to the processor |
| pullup_en | output | 1 | Pin pullup enable |

## Verification
Pin changes take three rising edges to reach the latch and `cpu_irq`: two synchronizer flops, then the latch. They take two rising edges to reach the pin-level bit. Register writes and acknowledges take effect one rising edge after the strobe. Read data and `pullup_en` follow the register state in the same cycle. The bench drives every input just after a falling edge and holds a cycle model that it advances at each rising edge from the stated delays. It compares all outputs at the next falling edge, so each result is checked in the exact cycle it is due. The directed cases also count those edges explicitly, for the pin-to-request delay and for a collision between an event and an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_OPT  = 1'b1;

    // control/status register bit positions
    localparam int CTRL_MASK_BIT = 0;
    localparam int CTRL_ACK_BIT  = 1;
    localparam int CTRL_MODE_BIT = 2;
    localparam int CTRL_FLAG_BIT = 3;
    localparam int CTRL_LVL_BIT  = 4;

    // option register bit positions
    localparam int OPT_SEC_EN_BIT = 0;
    localparam int OPT_SFLAG_BIT  = 1;
    localparam int OPT_PUDIS_BIT  = 2;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic       mask;
        trig_mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic sec_en;
        logic pu_dis;
    } opt_t;

    typedef struct packed {
        logic main_evt;
        logic sec_evt;
    } evt_t;

    // active-low trigger: low level, or a high-to-low step
    function automatic logic trig_hit(trig_mode_e m, logic prev, logic cur);
        return (m == TRIG_LEVEL) ? !cur : (prev && !cur);
    endfunction

    function automatic logic clear_allowed(logic brk, logic brk_clr);
        return !brk || brk_clr;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[LAST-1:0], pin_i[i]};
            end
        end

        assign sync_o[i] = chain_q[LAST];
    end

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       main_s,
    input  logic       sec_s,
    input  logic       sec_active,
    input  trig_mode_e mode,
    output logic       comb_lvl,
    output evt_t       evt
);

    logic comb_prev_q;
    logic sec_prev_q;

    // admitted sources are merged into one active-low level
    assign comb_lvl = main_s & (sec_active ? sec_s : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_prev_q <= 1'b1;
            sec_prev_q  <= 1'b1;
        end else begin
            comb_prev_q <= comb_lvl;
            sec_prev_q  <= sec_s;
        end
    end

    always_comb begin
        evt.main_evt = trig_hit(mode, comb_prev_q, comb_lvl);
        evt.sec_evt  = sec_active && trig_hit(mode, sec_prev_q, sec_s);
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              brk_state,
    input  logic              brk_clr_en,
    input  evt_t              evt,
    input  logic              comb_lvl,
    output ctrl_t             ctrl_o,
    output opt_t              opt_o,
    output logic              latch_o,
    output logic              sflag_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctrl_t ctrl_q;
    opt_t  opt_q;
    logic  latch_q;
    logic  sflag_q;

    logic wr_ctrl;
    logic wr_opt;
    logic clr_ok;
    logic ack_main;
    logic ack_sec;
    logic unused_wbits;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_opt   = bus_wr && (bus_addr == ADDR_OPT);
    assign clr_ok   = clear_allowed(brk_state, brk_clr_en);
    assign ack_main = wr_ctrl && bus_wdata[CTRL_ACK_BIT] && clr_ok;
    assign ack_sec  = wr_opt && bus_wdata[OPT_SFLAG_BIT] && clr_ok;
    assign unused_wbits = ^bus_wdata[DATA_W-1:CTRL_LVL_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{mask: 1'b0, mode: TRIG_EDGE};
            opt_q   <= '{sec_en: 1'b0, pu_dis: 1'b0};
            latch_q <= 1'b0;
            sflag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mask <= bus_wdata[CTRL_MASK_BIT];
                ctrl_q.mode <= trig_mode_e'(bus_wdata[CTRL_MODE_BIT]);
            end
            if (wr_opt) begin
                opt_q.sec_en <= bus_wdata[OPT_SEC_EN_BIT];
                opt_q.pu_dis <= bus_wdata[OPT_PUDIS_BIT];
            end
            // a new event wins over a same-cycle clear
            latch_q <= evt.main_evt || (latch_q && !ack_main);
            sflag_q <= evt.sec_evt  || (sflag_q && !ack_sec);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (bus_addr == ADDR_CTRL) begin
            rdata_o[CTRL_MASK_BIT] = ctrl_q.mask;
            rdata_o[CTRL_MODE_BIT] = ctrl_q.mode;
            rdata_o[CTRL_FLAG_BIT] = latch_q;
            rdata_o[CTRL_LVL_BIT]  = comb_lvl;
        end else begin
            rdata_o[OPT_SEC_EN_BIT] = opt_q.sec_en;
            rdata_o[OPT_SFLAG_BIT]  = sflag_q;
            rdata_o[OPT_PUDIS_BIT]  = opt_q.pu_dis;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign opt_o   = opt_q;
    assign latch_o = latch_q;
    assign sflag_o = sflag_q;

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_n,
    input  logic              sec_pin,
    input  logic              usb_en,
    input  logic              brk_state,
    input  logic              brk_clr_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq,
    output logic              pullup_en
);

    localparam int N_SRC = 2;

    logic [N_SRC-1:0] pins_raw;
    logic [N_SRC-1:0] pins_sync;
    ctrl_t ctrl;
    opt_t  opt;
    evt_t  evt;
    logic  comb_lvl;
    logic  sec_active;
    logic  latch_q;
    logic  sflag_q;
    logic  main_evt;
    logic  sec_evt;
    logic  sec_en_q;
    logic  mode_lvl;

    assign pins_raw   = {sec_pin, irq_n};
    assign sec_active = opt.sec_en && !usb_en;

    irq_pin_sync #(
        .WIDTH  (N_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pins_raw),
        .sync_o (pins_sync)
    );

    irq_trigger u_trig (
        .clk        (clk),
        .rst        (rst),
        .main_s     (pins_sync[0]),
        .sec_s      (pins_sync[1]),
        .sec_active (sec_active),
        .mode       (ctrl.mode),
        .comb_lvl   (comb_lvl),
        .evt        (evt)
    );

    irq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .brk_state  (brk_state),
        .brk_clr_en (brk_clr_en),
        .evt        (evt),
        .comb_lvl   (comb_lvl),
        .ctrl_o     (ctrl),
        .opt_o      (opt),
        .latch_o    (latch_q),
        .sflag_o    (sflag_q),
        .rdata_o    (bus_rdata)
    );

    assign main_evt  = evt.main_evt;
    assign sec_evt   = evt.sec_evt;
    assign sec_en_q  = opt.sec_en;
    assign mode_lvl  = (ctrl.mode == TRIG_LEVEL);
    assign cpu_irq   = latch_q && !ctrl.mask;
    assign pullup_en = !opt.pu_dis;

endmodule

// File: rtl/irq_checks.sv
module irq_checks
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              usb_en,
    input logic              brk_state,
    input logic              brk_clr_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              main_evt,
    input logic              sec_evt,
    input logic              latch_q,
    input logic              sflag_q,
    input logic              sec_en_q,
    input logic              mode_lvl,
    input logic              comb_lvl
);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        main_evt |=> latch_q);

    p_sec_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (!sflag_q && (usb_en || !sec_en_q)) |=> !sflag_q);

    p_sec_flag_r4: assert property (@(posedge clk) disable iff (rst)
        sec_evt |=> sflag_q);

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_CTRL && bus_wdata[CTRL_ACK_BIT]
         && (!brk_state || brk_clr_en) && !main_evt) |=> !latch_q);

    p_brk_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (brk_state && !brk_clr_en && latch_q) |=> latch_q);

    p_brk_sflag_r7: assert property (@(posedge clk) disable iff (rst)
        (brk_state && !brk_clr_en && sflag_q) |=> sflag_q);

    p_level_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_lvl && !comb_lvl) |=> latch_q);

endmodule

bind ext_irq_unit irq_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .usb_en     (usb_en),
    .brk_state  (brk_state),
    .brk_clr_en (brk_clr_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .main_evt   (main_evt),
    .sec_evt    (sec_evt),
    .latch_q    (latch_q),
    .sflag_q    (sflag_q),
    .sec_en_q   (sec_en_q),
    .mode_lvl   (mode_lvl),
    .comb_lvl   (comb_lvl)
);

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_n = 1'b1;
    logic       sec_pin = 1'b1;
    logic       usb_en = 1'b0;
    logic       brk_state = 1'b0;
    logic       brk_clr_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [0:0] bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_irq;
    logic       pullup_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit rnd_mode = 0;
    string tag = "R1";

    ext_irq_unit dut (
        .clk        (clk),
        .rst        (rst),
        .irq_n      (irq_n),
        .sec_pin    (sec_pin),
        .usb_en     (usb_en),
        .brk_state  (brk_state),
        .brk_clr_en (brk_clr_en),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cpu_irq    (cpu_irq),
        .pullup_en  (pullup_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // cycle model built from the requirements
    logic m_s1m, m_s2m, m_s1s, m_s2s, m_cprev, m_sprev;
    logic m_latch, m_sflag, m_mask, m_mode, m_sen, m_pud;

    function automatic logic exp_comb();
        logic act;
        act = m_sen && !usb_en;
        return m_s2m & (act ? m_s2s : 1'b1);
    endfunction

    always @(posedge clk) begin
        logic act, comb, mevt, sevt, ok, ackc, acks;
        if (rst) begin
            m_s1m = 1; m_s2m = 1; m_s1s = 1; m_s2s = 1;
            m_cprev = 1; m_sprev = 1;
            m_latch = 0; m_sflag = 0; m_mask = 0; m_mode = 0;
            m_sen = 0; m_pud = 0;
        end else begin
            act  = m_sen && !usb_en;
            comb = m_s2m & (act ? m_s2s : 1'b1);
            mevt = m_mode ? !comb : (m_cprev && !comb);
            sevt = act && (m_mode ? !m_s2s : (m_sprev && !m_s2s));
            ok   = !brk_state || brk_clr_en;
            ackc = bus_wr && bus_addr == 1'b0 && bus_wdata[1];
            acks = bus_wr && bus_addr == 1'b1 && bus_wdata[1];
            m_latch = mevt || (m_latch && !(ackc && ok));
            m_sflag = sevt || (m_sflag && !(acks && ok));
            m_cprev = comb;
            m_sprev = m_s2s;
            m_s2m = m_s1m; m_s1m = irq_n;
            m_s2s = m_s1s; m_s1s = sec_pin;
            if (bus_wr && bus_addr == 1'b0) begin
                m_mask = bus_wdata[0];
                m_mode = bus_wdata[2];
            end
            if (bus_wr && bus_addr == 1'b1) begin
                m_sen = bus_wdata[0];
                m_pud = bus_wdata[2];
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [7:0] e;
        check(rnd_mode ? "R5" : tag, "cpu_irq", {7'd0, cpu_irq},
              {7'd0, m_latch && !m_mask});
        if (bus_addr == 1'b0)
            e = {3'b0, exp_comb(), m_latch, m_mode, 1'b0, m_mask};
        else
            e = {5'b0, m_pud, m_sflag, m_sen};
        check(rnd_mode ? (bus_addr == 1'b0 ? "R10" : "R4") : tag,
              "rdata", bus_rdata, e);
        check(rnd_mode ? "R11" : tag, "pullup_en", {7'd0, pullup_en},
              {7'd0, !m_pud});
    endtask

    task automatic cyc();
        @(negedge clk);
        if (!rst) compare_model();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0; bus_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        cyc();

        // R1 reset values
        tag = "R1";
        bus_addr = 0;
        @(negedge clk);
        check("R1", "ctrl reset", bus_rdata, 8'h10);
        check("R1", "cpu_irq reset", {7'd0, cpu_irq}, 8'h00);
        check("R1", "pullup reset", {7'd0, pullup_en}, 8'h01);
        bus_addr = 1;
        @(negedge clk);
        check("R1", "opt reset", bus_rdata, 8'h00);
        bus_addr = 0;

        // R2 edge trigger, explicit cycle count
        tag = "R2";
        irq_n = 0;
        cyc(); cyc();
        check("R2", "no irq after 2 edges", {7'd0, cpu_irq}, 8'h00);
        check("R10", "level low after 2 edges", {7'd0, bus_rdata[4]}, 8'h00);
        cyc();
        check("R2", "irq after 3 edges", {7'd0, cpu_irq}, 8'h01);
        idle(3);

        // R6 acknowledge clears, reads 0
        tag = "R6";
        wr(0, 8'h02);
        check("R6", "latch cleared", {7'd0, cpu_irq}, 8'h00);
        check("R6", "ack reads 0", {7'd0, bus_rdata[1]}, 8'h00);
        irq_n = 1; idle(4);

        // R5 mask
        tag = "R5";
        wr(0, 8'h01);
        irq_n = 0; idle(4);
        check("R5", "masked irq", {7'd0, cpu_irq}, 8'h00);
        check("R5", "flag set under mask", {7'd0, bus_rdata[3]}, 8'h01);
        wr(0, 8'h00);
        check("R5", "unmask raises irq", {7'd0, cpu_irq}, 8'h01);
        wr(0, 8'h02); irq_n = 1; idle(4);

        // R3 / R4 secondary source gating and flag
        tag = "R3";
        usb_en = 1; wr(1, 8'h01);
        sec_pin = 0; idle(5);
        check("R3", "blocked by usb_en", {7'd0, cpu_irq}, 8'h00);
        sec_pin = 1; idle(4);
        usb_en = 0; idle(2);
        sec_pin = 0; idle(4);
        check("R3", "secondary sets latch", {7'd0, cpu_irq}, 8'h01);
        tag = "R4";
        bus_addr = 1; @(negedge clk);
        check("R4", "secondary flag", {7'd0, bus_rdata[1]}, 8'h01);
        sec_pin = 1; idle(3);
        wr(1, 8'h03);
        check("R4", "flag cleared", {7'd0, bus_rdata[1]}, 8'h00);
        wr(1, 8'h00); wr(0, 8'h02);
        sec_pin = 0; idle(5);
        tag = "R3";
        check("R3", "disabled secondary ignored", {7'd0, cpu_irq}, 8'h00);
        sec_pin = 1; idle(3);

        // R7 break protection
        tag = "R7";
        irq_n = 0; idle(4); irq_n = 1; idle(2);
        wr(1, 8'h01); sec_pin = 0; idle(4); sec_pin = 1; idle(2);
        brk_state = 1; brk_clr_en = 0;
        wr(0, 8'h02);
        wr(1, 8'h03);
        check("R7", "sflag kept in break", {7'd0, bus_rdata[1]}, 8'h01);
        bus_addr = 0; @(negedge clk);
        check("R7", "latch kept in break", {7'd0, bus_rdata[3]}, 8'h01);

        // R8 break clear enabled
        tag = "R8";
        brk_clr_en = 1;
        wr(0, 8'h02);
        brk_state = 0; brk_clr_en = 0; idle(2);
        check("R8", "stays cleared after break", {7'd0, bus_rdata[3]}, 8'h00);
        wr(1, 8'h03); wr(1, 8'h00);

        // R9 level mode
        tag = "R9";
        wr(0, 8'h04);
        irq_n = 0; idle(4);
        wr(0, 8'h06);
        check("R9", "held low re-asserts", {7'd0, cpu_irq}, 8'h01);
        irq_n = 1; idle(3);
        wr(0, 8'h06);
        check("R9", "released then ack", {7'd0, cpu_irq}, 8'h00);
        wr(0, 8'h00);

        // R11 pullup disable
        tag = "R11";
        wr(1, 8'h04);
        check("R11", "pullup off", {7'd0, pullup_en}, 8'h00);
        wr(1, 8'h00);
        check("R11", "pullup on", {7'd0, pullup_en}, 8'h01);

        // R12 event vs acknowledge in the same cycle
        tag = "R12";
        bus_addr = 0; idle(2);
        irq_n = 0; cyc(); cyc();
        wr(0, 8'h02);
        check("R12", "event wins", {7'd0, cpu_irq}, 8'h01);
        irq_n = 1; idle(3); wr(0, 8'h02);

        // constrained random mix
        rnd_mode = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) irq_n = ~irq_n;
            if ($urandom_range(7) == 0) sec_pin = ~sec_pin;
            if ($urandom_range(40) == 0) usb_en = ~usb_en;
            if ($urandom_range(30) == 0) brk_state = ~brk_state;
            if ($urandom_range(10) == 0) brk_clr_en = $urandom_range(1);
            bus_addr = $urandom_range(1);
            if ($urandom_range(5) == 0) begin
                bus_wr = 1;
                bus_wdata = 8'($urandom_range(255));
            end else begin
                bus_wr = 0;
            end
            cyc();
        end
        bus_wr = 0;
        finish_run();
    end

endmodule